// File: doc/BRIEF.md
# Configuration Header Register File

This block holds the 256-byte configuration space of one PCI function and serves byte, word and doubleword accesses to it. Each access gives a byte offset and a length code. A read returns the addressed bytes packed little-endian in the same cycle. A write updates the storage on the next clock edge.

A doubleword write that lands on one of the six base address registers or on the expansion ROM base is a region write, provided that region has a nonzero size. The written value is cut down to the region's alignment before it is stored. For a base register, the fixed type bits are then forced into the low nibble. For the ROM base, the enable flag in bit 0 is kept. A region write also raises a one-cycle `map_update` pulse, so a downstream address decoder can reload its windows.

Every other write is handled one byte at a time, starting with the lowest byte. Bytes that are read-only for the function's header type are skipped. The identity fields, the region sizes and the type bits are parameters.

Top module: `cfg_header_regs`

## Requirements
- R1: After reset, these bytes hold their parameter values: offsets 0x00–0x01 vendor ID, 0x02–0x03 device ID, 0x08 revision, 0x09–0x0B class code and 0x0E header type, all little-endian. Every other byte reads zero.
- R2: `acc_len` is coded 0 = one byte, 1 = two bytes, 2 or 3 = four bytes. `rd_data` returns the byte at `acc_off` in bits 7:0, the next byte up in bits 15:8, and so on. Offsets wrap modulo 256, and bits above the access length read zero.
- R3: A four-byte write is a region write when its offset is in 0x10–0x27 and the region (offset − 0x10) >> 2 has a nonzero size. Its four bytes, starting at `acc_off`, then store `(wr_data & ~(size−1)) | type`.
- R4: A four-byte write at an offset in 0x30–0x33 targets the ROM region. If the ROM size is nonzero, it stores `wr_data & (~(size−1) | 1)`, so bit 0 (ROM enable) is kept.
- R5: A four-byte write to a region of size zero is handled like any other write: byte by byte, with the protection rules applied.
- R6: A non-region write stores byte k of `wr_data` at offset `acc_off + k` (mod 256), for k from 0 up to the access length minus one.
- R7: When the header type byte is 0x00 or 0x80, byte-wise writes leave these offsets unchanged: 0x00–0x03, 0x08–0x0B, 0x0E, 0x10–0x27, 0x30–0x33 and 0x3D.
- R8: For any other header type value, byte-wise writes leave these offsets unchanged: 0x00–0x03, 0x08–0x0B, 0x0E, 0x38–0x3B and 0x3D.
- R9: `map_update` is high for exactly the one cycle after the clock edge that performs a region write, and low at all other times.
- R10: One- and two-byte writes to region offsets never take the region path. They follow R6 to R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_off | input | 8 | Byte offset of the access |
| acc_len | input | 2 | Length code: 0 byte, 1 word, 2/3 doubleword |
| wr_en | input | 1 | Perform a write this cycle |
| wr_data | input | 32 | Write data, little-endian |
| rd_data | output | 32 | Read data, little-endian |
| map_update | output | 1 | One-cycle pulse after a region write |

## Verification
The case hardest to reach from the ports is the interaction between the header type and the region path. The header byte is itself read-only, so it cannot be changed at run time. The bench therefore runs three instances side by side, with header types 0x00, 0x80 and 0x01, and feeds all three the same traffic. The same doubleword to a base register offset is masked in one instance, stored raw in another, or dropped, depending on the region size and the protection set. The stimulus also drives unaligned doublewords inside the region windows, writes to a zero-size region, and a write at offset 0xFE that wraps past the top of the space.

// File: rtl/cfg_header_regs.sv
module cfg_header_regs #(
  parameter logic [15:0]     VENDOR_ID   = 16'hA5C3,
  parameter logic [15:0]     DEVICE_ID   = 16'h3C71,
  parameter logic [7:0]      REVISION    = 8'h02,
  parameter logic [23:0]     CLASS_CODE  = 24'h060400,
  parameter logic [7:0]      HEADER_TYPE = 8'h00,
  parameter int              NUM_BAR     = 6,
  parameter logic [NUM_BAR*32-1:0] BAR_SIZE =
    {32'h0, 32'h20, 32'h0, 32'h40, 32'h1000, 32'h100},
  parameter logic [NUM_BAR*4-1:0]  BAR_TYPE =
    {4'h0, 4'h1, 4'h0, 4'h8, 4'h0, 4'h1},
  parameter logic [31:0]     ROM_SIZE    = 32'h800
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  acc_off,
  input  logic [1:0]  acc_len,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        map_update
);
  localparam int DEPTH    = 256;
  localparam int LANES    = 4;
  localparam logic [7:0] BAR_LO = 8'h10;
  localparam logic [7:0] BAR_HI = BAR_LO + 8'(NUM_BAR * 4);
  localparam logic [7:0] ROM_LO = 8'h30;
  localparam logic [7:0] HDR_AT = 8'h0E;

  logic [7:0] cfg [DEPTH];

  function automatic logic [7:0] init_byte(input int a);
    case (a)
      0:  return VENDOR_ID[7:0];
      1:  return VENDOR_ID[15:8];
      2:  return DEVICE_ID[7:0];
      3:  return DEVICE_ID[15:8];
      8:  return REVISION;
      9:  return CLASS_CODE[7:0];
      10: return CLASS_CODE[15:8];
      11: return CLASS_CODE[23:16];
      14: return HEADER_TYPE;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic locked(input logic [7:0] hdr, input logic [7:0] a);
    logic base;
    base = (a <= 8'h03) || (a >= 8'h08 && a <= 8'h0B) || a == 8'h0E || a == 8'h3D;
    if (hdr == 8'h00 || hdr == 8'h80)
      return base || (a >= 8'h10 && a <= 8'h27) || (a >= 8'h30 && a <= 8'h33);
    return base || (a >= 8'h38 && a <= 8'h3B);
  endfunction

  logic [2:0]  nbytes;
  logic        span, rom_sel, region_wr;
  logic [7:0]  rel;
  logic [31:0] sel_size, masked;
  logic [3:0]  sel_type;

  assign nbytes  = acc_len[1] ? 3'd4 : (acc_len[0] ? 3'd2 : 3'd1);
  assign rom_sel = acc_off >= ROM_LO && acc_off < ROM_LO + 8'd4;
  assign span    = (acc_off >= BAR_LO && acc_off < BAR_HI) || rom_sel;
  assign rel     = (acc_off - BAR_LO) >> 2;

  always_comb begin
    sel_size = '0;
    sel_type = '0;
    for (int i = 0; i < NUM_BAR; i++)
      if (rel == 8'(i)) begin
        sel_size = BAR_SIZE[i*32 +: 32];
        sel_type = BAR_TYPE[i*4 +: 4];
      end
    if (rom_sel) begin
      sel_size = ROM_SIZE;
      sel_type = '0;
    end
  end

  assign region_wr = wr_en && acc_len[1] && span && sel_size != '0;
  assign masked = rom_sel ? (wr_data & (~(sel_size - 32'd1) | 32'd1))
                          : ((wr_data & ~(sel_size - 32'd1)) | {28'd0, sel_type});

  logic [7:0] lane_addr [LANES];
  logic [7:0] lane_val  [LANES];
  logic       lane_we   [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_addr[g] = acc_off + 8'(g);
    assign lane_val[g]  = region_wr ? masked[g*8 +: 8] : wr_data[g*8 +: 8];
    assign lane_we[g]   = region_wr ||
                          (wr_en && 3'(g) < nbytes && !locked(cfg[HDR_AT], lane_addr[g]));
    assign rd_data[g*8 +: 8] = (3'(g) < nbytes) ? cfg[lane_addr[g]] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) cfg[a] <= init_byte(a);
      map_update <= 1'b0;
    end else begin
      for (int i = 0; i < LANES; i++)
        if (lane_we[i]) cfg[lane_addr[i]] <= lane_val[i];
      map_update <= region_wr;
    end
  end
endmodule

// File: rtl/cfg_header_regs_chk.sv
module cfg_header_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  acc_len,
  input logic        wr_en,
  input logic [31:0] rd_data,
  input logic        map_update,
  input logic [7:0]  hdr_byte,
  input logic [31:0] id_word
);
  assert_byte_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_len == 2'd0 |-> rd_data[31:8] == 24'd0);
  assert_word_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_len == 2'd1 |-> rd_data[31:16] == 16'd0);
  assert_pulse_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    map_update |-> $past(wr_en) && $past(acc_len[1]));
  assert_no_pulse_short_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !acc_len[1]) |=> !map_update);
  assert_hdr_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(hdr_byte));
  assert_id_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(id_word));
endmodule

bind cfg_header_regs cfg_header_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acc_len(acc_len), .wr_en(wr_en),
  .rd_data(rd_data), .map_update(map_update),
  .hdr_byte(cfg[14]), .id_word({cfg[3], cfg[2], cfg[1], cfg[0]})
);

// File: tb/cfg_header_regs_tb.sv
module cfg_header_regs_tb;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [7:0]  acc_off = 0;
  logic [1:0]  acc_len = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd0, rd1, rd2;
  logic pu0, pu1, pu2;

  always #4 clk = ~clk;

  cfg_header_regs #(.HEADER_TYPE(8'h00)) u_dut (.clk(clk), .rst_n(rst_n),
    .acc_off(acc_off), .acc_len(acc_len), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd0), .map_update(pu0));
  cfg_header_regs #(.HEADER_TYPE(8'h80)) u_dut_mf (.clk(clk), .rst_n(rst_n),
    .acc_off(acc_off), .acc_len(acc_len), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd1), .map_update(pu1));
  cfg_header_regs #(.HEADER_TYPE(8'h01)) u_dut_br (.clk(clk), .rst_n(rst_n),
    .acc_off(acc_off), .acc_len(acc_len), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd2), .map_update(pu2));

  int errors = 0, checks = 0, cyc = 0;
  bit chk_on = 0;
  string cur_req = "R1";
  byte unsigned mdl [3][256];
  bit exp_pu [3];
  int hdr_of [3] = '{8'h00, 8'h80, 8'h01};
  int rsz  [7] = '{256, 4096, 64, 0, 32, 0, 2048};
  int rtyp [6] = '{1, 0, 8, 0, 1, 0};

  function automatic int nb(input logic [1:0] l);
    return l[1] ? 4 : (l[0] ? 2 : 1);
  endfunction

  function automatic void mreset(input int k);
    foreach (mdl[k][a]) mdl[k][a] = 0;
    mdl[k][0] = 8'hC3; mdl[k][1] = 8'hA5; mdl[k][2] = 8'h71; mdl[k][3] = 8'h3C;
    mdl[k][8] = 8'h02; mdl[k][9] = 8'h00; mdl[k][10] = 8'h04; mdl[k][11] = 8'h06;
    mdl[k][14] = 8'(hdr_of[k]);
  endfunction

  function automatic bit prot(input int h, input int a);
    bit c = a <= 3 || (a >= 8 && a <= 11) || a == 14 || a == 61;
    if (h == 0 || h == 8'h80) return c || (a >= 16 && a <= 39) || (a >= 48 && a <= 51);
    return c || (a >= 56 && a <= 59);
  endfunction

  function automatic bit mwrite(input int k, input int off, input logic [1:0] l,
                                input logic [31:0] d);
    int n = nb(l);
    if (n == 4 && ((off >= 16 && off < 40) || (off >= 48 && off < 52))) begin
      int r = (off >= 48) ? 6 : (off - 16) / 4;
      if (rsz[r] != 0) begin
        logic [31:0] v;
        logic [31:0] m = ~(32'(rsz[r]) - 1);
        v = (r == 6) ? (d & (m | 1)) : ((d & m) | 32'(rtyp[r]));
        for (int i = 0; i < 4; i++) mdl[k][(off + i) % 256] = v[8*i +: 8];
        return 1;
      end
    end
    for (int i = 0; i < n; i++) begin
      int a = (off + i) % 256;
      if (!prot(mdl[k][14], a)) mdl[k][a] = d[8*i +: 8];
    end
    return 0;
  endfunction

  function automatic logic [31:0] mread(input int k, input int off, input logic [1:0] l);
    logic [31:0] r = 0;
    for (int i = 0; i < nb(l); i++) r[8*i +: 8] = mdl[k][(off + i) % 256];
    return r;
  endfunction

  always @(posedge clk) begin
    for (int k = 0; k < 3; k++) begin
      if (!rst_n) begin mreset(k); exp_pu[k] = 0; end
      else begin
        exp_pu[k] = 0;
        if (wr_en) exp_pu[k] = mwrite(k, acc_off, acc_len, wr_data);
      end
    end
  end

  task automatic cmp(input int k, input logic [31:0] got, input logic gp);
    logic [31:0] e = mread(k, acc_off, acc_len);
    checks += 2;
    if (got !== e) begin
      errors++;
      $display("FAIL %s dut%0d off=%h len=%0d rd_data=%h expected=%h",
               cur_req, k, acc_off, acc_len, got, e);
    end
    if (gp !== exp_pu[k]) begin
      errors++;
      $display("FAIL R9 dut%0d map_update=%0b expected=%0b", k, gp, exp_pu[k]);
    end
  endtask

  always @(negedge clk) if (chk_on) begin
    cmp(0, rd0, pu0);
    cmp(1, rd1, pu1);
    cmp(2, rd2, pu2);
  end

  task automatic op(input int off, input int l, input bit we, input logic [31:0] d);
    @(posedge clk); #1;
    acc_off = 8'(off); acc_len = 2'(l); wr_en = we; wr_data = d;
  endtask

  task automatic sweep_read();
    for (int a = 0; a < 256; a++) op(a, 2, 0, 0);
    for (int a = 0; a < 64; a++) op(a, a % 2, 0, 0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1; chk_on = 1;
    cur_req = "R1"; sweep_read();
    cur_req = "R2"; op(8'hFE, 2, 0, 0); op(8'hFF, 1, 0, 0); op(3, 3, 0, 0);
    cur_req = "R3";
    for (int r = 0; r < 6; r++) begin
      op(16 + 4*r, 2, 1, 32'hFFFF_FFFF); op(16 + 4*r, 2, 0, 0);
      op(16 + 4*r, 2, 1, 32'h1234_5677); op(16 + 4*r, 2, 0, 0);
    end
    op(8'h11, 2, 1, 32'hDEAD_BEEF); op(8'h10, 3, 0, 0); op(8'h11, 2, 0, 0);
    cur_req = "R4";
    op(8'h30, 2, 1, 32'hFFFF_FFFF); op(8'h30, 2, 0, 0);
    op(8'h30, 2, 1, 32'hCAFE_F800); op(8'h30, 2, 0, 0);
    op(8'h33, 2, 1, 32'h8765_4321); op(8'h30, 2, 0, 0); op(8'h33, 2, 0, 0);
    cur_req = "R5";
    op(8'h1C, 2, 1, 32'hA1B2_C3D4); op(8'h1C, 2, 0, 0);
    op(8'h24, 2, 1, 32'h0F0F_0F0F); op(8'h24, 2, 0, 0);
    cur_req = "R10";
    op(8'h10, 0, 1, 32'h55); op(8'h10, 2, 0, 0);
    op(8'h14, 1, 1, 32'h9ABC); op(8'h14, 2, 0, 0);
    cur_req = "R6";
    op(8'h40, 2, 1, 32'h0403_0201); op(8'h40, 2, 0, 0);
    op(8'h45, 1, 1, 32'hBEEF); op(8'h44, 2, 0, 0);
    op(8'hFE, 2, 1, 32'h8877_6655); op(8'hFE, 2, 0, 0); op(0, 2, 0, 0);
    cur_req = "R7";
    for (int a = 0; a < 64; a++) op(a, 0, 1, 32'hFF);
    sweep_read();
    cur_req = "R8";
    for (int a = 0; a < 64; a += 4) op(a, 2, 1, 32'h5AA5_C33C);
    sweep_read();
    cur_req = "R9";
    op(8'h18, 2, 1, 32'h1111_1111); op(8'h18, 2, 1, 32'h2222_2222);
    op(8'h18, 2, 0, 0); op(8'h18, 2, 0, 0);
    cur_req = "R3";
    for (int i = 0; i < 3000; i++) begin
      int off = ($urandom % 4 == 0) ? int'($urandom % 256) : int'($urandom % 64);
      op(off, int'($urandom % 4), bit'($urandom % 2), $urandom);
    end
    cur_req = "R1";
    rst_n = 0; op(0, 2, 0, 0); op(0, 2, 0, 0);
    #1 rst_n = 1; sweep_read();
    wr_en = 0;
    @(posedge clk); @(negedge clk);
    chk_on = 0;
    finish_run();
  end
endmodule